// File: doc/BRIEF.md
# Chained Time-Slot Serial Slave

This block is one member of a chain of slaves that share a framed serial bus. It sits idle with its data driver released until a frame-sync pulse reaches its sync input. It then owns the bus for exactly one word. It shifts out a parallel transmit word, most significant bit first, and at the same time assembles a receive word from the incoming data line. During the last bit of its word it raises a one-period sync output. That output is wired to the sync input of the next slave in the chain, so that slave takes the slot that follows with no gap. The slot position of each device is therefore set by where it sits in the chain, not by a programmed index.

All logic runs on the serial bit clock (`clk`). The sync input and the incoming data are registered on the rising edge. Outgoing data, the output enable and the sync output change only on the rising edge. The output enable is meant to control an external tri-state driver. The word width is a parameter of at least 2.

The controller has three states. IDLE means the driver is released. SHIFT means a bit other than the last is driven. LAST means the final bit is driven and the sync output is high. The transitions are named as follows. *accept* (IDLE→SHIFT) occurs when sync is sampled high. *penultimate* (SHIFT→LAST) occurs when the bit counter reaches width−2. *finish* (LAST→IDLE) occurs when sync is low. *rechain* (LAST→SHIFT) occurs when sync is sampled high at the edge that ends the last bit. SHIFT stays in SHIFT on every other edge, whatever the sync input does.

Top module: `chain_slot_slave`

## Requirements
- R1: While `rst_n` is low and just after its release, `sd_oe`, `sd_out`, `fso_out`, `rx_valid` and `rx_word` are all 0.
- R2: When `fs_in` is high at a rising edge while the block is idle, `sd_oe` goes high from that edge and stays high for exactly W clock periods.
- R3: During the k-th period of the window (k = 0 … W−1), `sd_out` carries bit W−1−k of the transmit word, so the MSB goes first.
- R4: The transmit word is taken from `tx_word` at the accepting edge. Changes to `tx_word` during the window do not alter the bits driven.
- R5: `fso_out` is high during the final bit period of the window only, for exactly one period, and never outside the window.
- R6: `sd_in` is sampled at each rising edge that ends a window period, MSB first. At the edge that ends the window, `rx_word` takes the assembled word and `rx_valid` is high for exactly one period.
- R7: A high `fs_in` sampled at an edge inside the window, other than the edge that ends it, is ignored. The window keeps its length of W periods and its data.
- R8: A high `fs_in` sampled at the edge that ends the window starts a new window at once (rechain). `sd_oe` then stays high with no gap, and the new word is loaded from `tx_word` at that edge.
- R9: Whenever `sd_oe` is low, `sd_out` is 0.
- R10: With `fso_out` wired to the `fs_in` of a second instance, the second instance drives its W bits in the W periods that directly follow the first instance's window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_in | input | 1 | Frame-sync input from the master or the previous slave |
| tx_word | input | W | Word to transmit in this device's slot |
| sd_in | input | 1 | Serial receive data line |
| sd_out | output | 1 | Serial transmit data, for an external tri-state driver |
| sd_oe | output | 1 | Drive enable for `sd_out`, high only during this device's slot |
| fso_out | output | 1 | Frame-sync output to the next slave in the chain |
| rx_word | output | W | Last word received in this device's slot |
| rx_valid | output | 1 | One-period strobe when `rx_word` has been updated |

## Verification
Sync is accepted at edge e. Bit k is then valid on `sd_out` in the period after edge e+k. The sync output is high in the period after edge e+W−1. The received word and its strobe appear in the period after edge e+W. The chained second device drives bit k in the period after edge e+W+k. The bench drives all inputs and samples all outputs at falling edges, and indexes every check by the number of rising edges since the accepting edge. Each expectation therefore lands in exactly the period those latencies name. The sweep covers every 8-bit transmit value and adds a stray sync mid-window, a transmit-word change mid-window and back-to-back windows.

// File: rtl/slot_chain_pkg.sv
package slot_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LAST  = 2'd2
    } slot_state_e;

endpackage

// File: rtl/slot_bit_counter.sv
module slot_bit_counter #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic active_i,
    output logic penult_o
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] PENULT = CW'(W - 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
        end else if (active_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign penult_o = (cnt_q == PENULT);

endmodule

// File: rtl/slot_ctrl_fsm.sv
module slot_ctrl_fsm
    import slot_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fs_i,
    input  logic penult_i,
    output logic load_o,
    output logic active_o,
    output logic last_o
);
    slot_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (fs_i)     state_d = ST_SHIFT;   // accept
            ST_SHIFT: if (penult_i) state_d = ST_LAST;    // penultimate
            ST_LAST:  state_d = fs_i ? ST_SHIFT : ST_IDLE; // rechain / finish
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o   = 1'b0;
        active_o = 1'b0;
        last_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:  load_o = fs_i;
            ST_SHIFT: active_o = 1'b1;
            ST_LAST: begin
                active_o = 1'b1;
                last_o   = 1'b1;
                load_o   = fs_i;
            end
            default: ;
        endcase
    end

    AST_FSO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !last_o); // R5
    AST_MIDWORD_FS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && fs_i && !penult_i) |=> (state_q == ST_SHIFT)); // R7
    AST_RECHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && fs_i) |=> (active_o && !last_o)); // R8

endmodule

// File: rtl/slot_tx_shifter.sv
module slot_tx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         active_i,
    input  logic [W-1:0] word_i,
    output logic         bit_o
);
    logic [W-1:0] sreg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load_i) begin
            sreg_q <= word_i;
        end else if (active_i) begin
            sreg_q <= {sreg_q[W-2:0], 1'b0};
        end else begin
            sreg_q <= '0;
        end
    end

    assign bit_o = sreg_q[W-1];

endmodule

// File: rtl/slot_rx_shifter.sv
module slot_rx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active_i,
    input  logic         last_i,
    input  logic         sd_i,
    output logic [W-1:0] word_o,
    output logic         valid_o
);
    logic [W-2:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (active_i) begin
                if (W > 2) acc_q <= {acc_q[(W > 2 ? W-3 : 0):0], sd_i};
                else       acc_q <= sd_i;
            end
            if (last_i) begin
                word_o  <= {acc_q, sd_i};
                valid_o <= 1'b1;
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R6

endmodule

// File: rtl/chain_slot_slave.sv
module chain_slot_slave #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fs_in,
    input  logic [W-1:0] tx_word,
    input  logic         sd_in,
    output logic         sd_out,
    output logic         sd_oe,
    output logic         fso_out,
    output logic [W-1:0] rx_word,
    output logic         rx_valid
);
    logic load_w, active_w, last_w, penult_w, tx_bit_w;

    slot_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs_i     (fs_in),
        .penult_i (penult_w),
        .load_o   (load_w),
        .active_o (active_w),
        .last_o   (last_w)
    );

    slot_bit_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .active_i (active_w),
        .penult_o (penult_w)
    );

    slot_tx_shifter #(.W(W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .active_i (active_w),
        .word_i   (tx_word),
        .bit_o    (tx_bit_w)
    );

    slot_rx_shifter #(.W(W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active_w),
        .last_i   (last_w),
        .sd_i     (sd_in),
        .word_o   (rx_word),
        .valid_o  (rx_valid)
    );

    assign sd_oe   = active_w;
    assign fso_out = last_w;
    assign sd_out  = tx_bit_w;

    AST_START_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_oe && fs_in) |=> sd_oe); // R2
    AST_FSO_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        fso_out |-> sd_oe); // R5
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> !sd_out); // R9
    AST_FSO_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fso_out |=> rx_valid); // R6

endmodule

// File: tb/chain_slot_slave_bench.sv
module chain_slot_slave_bench;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fs = 1'b0;
    logic [W-1:0] tx_a = '0, tx_b = '0;
    logic sd_in = 1'b0;
    logic sd_out_a, sd_oe_a, fso_a, rxv_a;
    logic sd_out_b, sd_oe_b, fso_b, rxv_b;
    logic [W-1:0] rx_a, rx_b;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    chain_slot_slave #(.W(W)) u_chain_slot_slave (
        .clk(clk), .rst_n(rst_n), .fs_in(fs), .tx_word(tx_a), .sd_in(sd_in),
        .sd_out(sd_out_a), .sd_oe(sd_oe_a), .fso_out(fso_a),
        .rx_word(rx_a), .rx_valid(rxv_a)
    );

    chain_slot_slave #(.W(W)) u_next (
        .clk(clk), .rst_n(rst_n), .fs_in(fso_a), .tx_word(tx_b), .sd_in(sd_in),
        .sd_out(sd_out_b), .sd_oe(sd_oe_b), .fso_out(fso_b),
        .rx_word(rx_b), .rx_valid(rxv_b)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // one frame: dut window then chained window; optional stray sync and tx change
    task automatic frame(input logic [W-1:0] t, input logic [W-1:0] r,
                         input logic [W-1:0] t2, input int fs_mid, input bit chg);
        fs = 1'b1; tx_a = t; tx_b = t2;
        @(negedge clk);
        fs = 1'b0;
        for (int i = 0; i < 2*W; i++) begin
            if (i < W) begin
                chk(sd_oe_a == 1'b1, "R2 oe in window", 32'(sd_oe_a), 1);
                chk(sd_out_a == t[W-1-i], "R3/R4 tx bit", 32'(sd_out_a), 32'(t[W-1-i]));
                chk(fso_a == (i == W-1), "R5 fso timing", 32'(fso_a), 32'(i == W-1));
                chk(sd_oe_b == 1'b0, "R10 next idle", 32'(sd_oe_b), 0);
                sd_in = r[W-1-i];
                fs = (i == fs_mid);
                if (chg && i == 0) tx_a = ~t;
            end else begin
                chk(sd_oe_a == 1'b0, "R2 window length", 32'(sd_oe_a), 0);
                chk(sd_out_a == 1'b0, "R9 quiet out", 32'(sd_out_a), 0);
                chk(fso_a == 1'b0, "R5 fso outside", 32'(fso_a), 0);
                chk(sd_oe_b == 1'b1, "R10 next oe", 32'(sd_oe_b), 1);
                chk(sd_out_b == t2[2*W-1-i], "R10 next bit", 32'(sd_out_b), 32'(t2[2*W-1-i]));
                chk(rxv_a == (i == W), "R6 valid pulse", 32'(rxv_a), 32'(i == W));
                if (i == W) chk(rx_a == r, "R6 rx word", 32'(rx_a), 32'(r));
                fs = 1'b0;
                sd_in = 1'b0;
            end
            @(negedge clk);
        end
        chk(sd_oe_b == 1'b0, "R10 next done", 32'(sd_oe_b), 0);
    endtask

    task automatic back_to_back(input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic [W-1:0] r);
        fs = 1'b1; tx_a = a;
        @(negedge clk);
        for (int i = 0; i < W; i++) begin
            chk(sd_oe_a == 1'b1, "R8 first oe", 32'(sd_oe_a), 1);
            chk(sd_out_a == a[W-1-i], "R8 first bit", 32'(sd_out_a), 32'(a[W-1-i]));
            sd_in = r[W-1-i];
            fs = (i == W-1);
            if (i == W-1) tx_a = b;
            @(negedge clk);
        end
        for (int i = 0; i < W; i++) begin
            chk(sd_oe_a == 1'b1, "R8 no gap", 32'(sd_oe_a), 1);
            chk(sd_out_a == b[W-1-i], "R8 second bit", 32'(sd_out_a), 32'(b[W-1-i]));
            chk(rxv_a == (i == 0), "R6 valid rechain", 32'(rxv_a), 32'(i == 0));
            if (i == 0) chk(rx_a == r, "R6 rx rechain", 32'(rx_a), 32'(r));
            fs = 1'b0;
            sd_in = 1'b0;
            @(negedge clk);
        end
        chk(sd_oe_a == 1'b0, "R8 end", 32'(sd_oe_a), 0);
        chk(rxv_a == 1'b1 && rx_a == '0, "R6 second rx", 32'(rx_a), 0);
        repeat (3*W) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sd_oe_a == 0 && sd_out_a == 0 && fso_a == 0, "R1 reset outs",
            {29'd0, sd_oe_a, sd_out_a, fso_a}, 0);
        chk(rxv_a == 0 && rx_a == '0, "R1 reset rx", 32'(rx_a), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sd_oe_a == 0 && fso_a == 0 && rxv_a == 0, "R1 after release",
            {29'd0, sd_oe_a, fso_a, rxv_a}, 0);
        for (int v = 0; v < (1 << W); v++) begin
            logic [W-1:0] t;
            int mid;
            t = W'(v);
            mid = (v % 3 == 0) ? 1 + (v % (W-2)) : -1; // R7 stray sync
            frame(t, t ^ W'(8'hA5), ~t, mid, t[0]);   // R4 change when bit0 set
        end
        back_to_back(W'(8'h96), W'(8'h3C), W'(8'hE1));
        back_to_back(W'(8'hFF), W'(8'h00), W'(8'h5A));
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

endmodule